// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches address translations for a memory management unit that walks a two-level page table. It holds a parameterised number of entries, 64 by default, and any entry can hold any translation. Each entry keeps its own address mask, the virtual address ANDed with that mask, both raw descriptor words and a flag that says which descriptor supplies the physical base. Because every entry has its own mask, 1 MB section mappings, 64 KB large pages and 4 KB small pages sit side by side in one array.

A lookup is purely combinational. A 32-bit virtual address goes in, and the block returns hit or miss, the two descriptors of the matching entry and the physical address formed from that entry. The page-table walker writes new translations through a valid/ready fill stream. Each accepted fill goes to the slot named by a rotating allocation pointer. Two plain control pins remove entries: one clears the whole array, and the other clears only the entries that translate a given virtual address.

The fill stream follows these back-pressure rules. `fill_ready` depends only on the flush pins and never on `fill_valid`. It is low in any cycle where a flush is requested. A fill is taken on a rising clock edge where `fill_valid` and `fill_ready` are both high. While `fill_ready` is low, the producer must keep `fill_valid` and the fill fields steady until the transfer is taken.

Top module: `va_xlat_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `fill_ready` is high. The first accepted fill goes to entry 0.
- R2: A lookup hits when some valid entry satisfies (lookup address AND entry mask) == stored address. On a miss, `lk_hit`, `lk_paddr`, `lk_l1_desc` and `lk_l2_desc` are all 0.
- R3: On a hit, `lk_paddr` = (base AND mask) OR (lookup address AND NOT mask). The base is the stored second-level descriptor when the entry's page flag is 1, and the stored first-level descriptor when the flag is 0.
- R4: On a hit, `lk_l1_desc` and `lk_l2_desc` equal the descriptor words stored in the matching entry.
- R5: An accepted fill stores mask, (fill_vaddr AND fill_mask), both descriptors and the page flag at the allocation pointer. The pointer then advances by one and wraps from DEPTH-1 to 0, so fill number DEPTH+1 overwrites the entry of the first fill.
- R6: `fill_ready` is low in any cycle where `flush_all` or `flush_one` is high. A fill offered in that cycle is not stored and does not move the pointer.
- R7: `flush_all` invalidates every entry and returns the allocation pointer to 0. It takes precedence over `flush_one` in the same cycle.
- R8: `flush_one` invalidates exactly the valid entries that would hit for `flush_vaddr`. Other entries and the pointer are unchanged.
- R9: When several valid entries hit, the lowest-numbered entry supplies the outputs.
- R10: Lookup is combinational. A translation filled on a clock edge is visible on the lookup outputs in the cycle right after that edge, with no further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matches lk_vaddr |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| lk_l1_desc | output | 32 | First-level descriptor of the hit entry, 0 on miss |
| lk_l2_desc | output | 32 | Second-level descriptor of the hit entry, 0 on miss |
| fill_valid | input | 1 | Fill transfer offered |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vaddr | input | 32 | Virtual address of the new translation |
| fill_mask | input | 32 | Address mask of the new translation |
| fill_l1_desc | input | 32 | First-level descriptor word |
| fill_l2_desc | input | 32 | Second-level descriptor word |
| fill_is_page | input | 1 | 1: physical base taken from the second-level descriptor |
| flush_all | input | 1 | Invalidate all entries and reset the pointer |
| flush_one | input | 1 | Invalidate the entries that match flush_vaddr |
| flush_vaddr | input | 32 | Address used by flush_one |

## Verification
Some properties are checked on every cycle:
- The outputs on a miss are all zero.
- At most one entry is selected.
- After a flush-all nothing hits and the pointer is back at 0.
- An accepted fill advances the pointer with wrap.
- A fill offered during a single-address flush leaves the pointer alone.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- The translation arithmetic for sections and pages.
- Lowest-index priority between overlapping mappings.
- Which entries a single-address flush removes and which it keeps.
- The eviction of the oldest entry after a full wrap.
- The pointer reset made visible through priority order.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned VA_W   = 32;
  parameter int unsigned DESC_W = 32;

  typedef struct packed {
    logic [VA_W-1:0]   mask;
    logic [VA_W-1:0]   addr;
    logic [DESC_W-1:0] l1;
    logic [DESC_W-1:0] l2;
    logic              is_page;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clear) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_entry,
  input  logic             flush_all,
  input  logic             flush_one,
  input  logic [VA_W-1:0]  flush_va,
  input  logic [VA_W-1:0]  look_va,
  output logic [DEPTH-1:0] hit_vec,
  output tlb_entry_t       ent_q [DEPTH]
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] flush_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    // Both compares use the entry's own mask, so mapping sizes can differ per entry.
    assign hit_vec[g]   = valid_q[g] && ((look_va  & ent_q[g].mask) == ent_q[g].addr);
    assign flush_hit[g] = valid_q[g] && ((flush_va & ent_q[g].mask) == ent_q[g].addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (flush_all) begin
        valid_q[g] <= 1'b0;
      end else if (flush_one) begin
        if (flush_hit[g]) valid_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_q[g] <= wr_entry;
      end
    end
  end
endmodule

// File: rtl/tlb_select.sv
module tlb_select
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic [DEPTH-1:0] hit_vec,
  input  tlb_entry_t       ent_q [DEPTH],
  output logic [DEPTH-1:0] win_vec,
  output logic             any_hit,
  output tlb_entry_t       sel
);
  // Lowest-numbered hit wins.
  always_comb begin
    logic found;
    found   = 1'b0;
    win_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i] && !found) begin
        win_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign any_hit = |hit_vec;

  // AND-OR mux driven by the one-hot winner.
  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      sel = sel | (ent_q[i] & {$bits(tlb_entry_t){win_vec[i]}});
    end
  end
endmodule

// File: rtl/va_xlat_tlb.sv
module va_xlat_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [VA_W-1:0]   lk_paddr,
  output logic [DESC_W-1:0] lk_l1_desc,
  output logic [DESC_W-1:0] lk_l2_desc,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [VA_W-1:0]   fill_mask,
  input  logic [DESC_W-1:0] fill_l1_desc,
  input  logic [DESC_W-1:0] fill_l2_desc,
  input  logic              fill_is_page,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [VA_W-1:0]   flush_vaddr
);
  logic [IDX_W-1:0] alloc_ptr;
  logic             fill_take;
  tlb_entry_t       wr_entry;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] win_vec;
  tlb_entry_t       ent_q [DEPTH];
  tlb_entry_t       sel;
  logic             any_hit;
  logic [VA_W-1:0]  base;

  // Flushes own the array for their cycle, so the fill stream is stalled.
  assign fill_ready = !(flush_all || flush_one);
  assign fill_take  = fill_valid && fill_ready;

  always_comb begin
    wr_entry.mask    = fill_mask;
    wr_entry.addr    = fill_vaddr & fill_mask;
    wr_entry.l1      = fill_l1_desc;
    wr_entry.l2      = fill_l2_desc;
    wr_entry.is_page = fill_is_page;
  end

  tlb_rr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush_all),
    .advance (fill_take),
    .ptr     (alloc_ptr)
  );

  tlb_array #(.DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fill_take),
    .wr_idx    (alloc_ptr),
    .wr_entry  (wr_entry),
    .flush_all (flush_all),
    .flush_one (flush_one),
    .flush_va  (flush_vaddr),
    .look_va   (lk_vaddr),
    .hit_vec   (hit_vec),
    .ent_q     (ent_q)
  );

  tlb_select #(.DEPTH(DEPTH)) u_sel (
    .hit_vec (hit_vec),
    .ent_q   (ent_q),
    .win_vec (win_vec),
    .any_hit (any_hit),
    .sel     (sel)
  );

  assign base       = VA_W'(sel.is_page ? sel.l2 : sel.l1);
  assign lk_hit     = any_hit;
  assign lk_paddr   = any_hit ? ((base & sel.mask) | (lk_vaddr & ~sel.mask)) : '0;
  assign lk_l1_desc = sel.l1;
  assign lk_l2_desc = sel.l2;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_all,
  input logic             flush_one,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             lk_hit,
  input logic [31:0]      lk_paddr,
  input logic [31:0]      lk_l1_desc,
  input logic [31:0]      lk_l2_desc,
  input logic [DEPTH-1:0] win_vec,
  input logic [IDX_W-1:0] alloc_ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && lk_l1_desc == '0 && lk_l2_desc == '0));

  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && (lk_hit == (win_vec != '0)));

  p_ptr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=>
      (alloc_ptr == (($past(alloc_ptr) == LAST) ? '0 : $past(alloc_ptr) + 1'b1)));

  p_fill_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_one && !flush_all && fill_valid) |=> $stable(alloc_ptr));

  p_flush_all_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (!lk_hit && alloc_ptr == '0));
endmodule

bind va_xlat_tlb tlb_checker #(.DEPTH(DEPTH)) u_tlb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_all  (flush_all),
  .flush_one  (flush_one),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .lk_hit     (lk_hit),
  .lk_paddr   (lk_paddr),
  .lk_l1_desc (lk_l1_desc),
  .lk_l2_desc (lk_l2_desc),
  .win_vec    (win_vec),
  .alloc_ptr  (alloc_ptr)
);

// File: tb/test_va_xlat_tlb.sv
module test_va_xlat_tlb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr, lk_l1_desc, lk_l2_desc;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [31:0] fill_vaddr = '0, fill_mask = '0, fill_l1_desc = '0, fill_l2_desc = '0;
  logic        fill_is_page = 1'b0;
  logic        flush_all = 1'b0, flush_one = 1'b0;
  logic [31:0] flush_vaddr = '0;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  bit          m_v   [N];
  logic [31:0] m_msk [N];
  logic [31:0] m_adr [N];
  logic [31:0] m_l1  [N];
  logic [31:0] m_l2  [N];
  bit          m_pg  [N];
  int          m_ptr = 0;

  always #10 clk = ~clk;

  va_xlat_tlb i_va_xlat_tlb (.*);

  function automatic int model_find(logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (m_v[i] && ((va & m_msk[i]) == m_adr[i])) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_pa(int k, logic [31:0] va);
    logic [31:0] b;
    b = m_pg[k] ? m_l2[k] : m_l1[k];
    return (b & m_msk[k]) | (va & ~m_msk[k]);
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model at the edge.
  task automatic step(bit fa, bit fo, logic [31:0] fva, bit fv, logic [31:0] va,
                      logic [31:0] msk, logic [31:0] l1, logic [31:0] l2, bit pg,
                      logic [31:0] lva, string tag);
    int k;
    flush_all = fa; flush_one = fo; flush_vaddr = fva;
    fill_valid = fv; fill_vaddr = va; fill_mask = msk;
    fill_l1_desc = l1; fill_l2_desc = l2; fill_is_page = pg;
    lk_vaddr = lva;
    #5;
    k = model_find(lva);
    cmp(tag, "fill_ready", {31'd0, fill_ready}, {31'd0, !(fa || fo)});
    cmp(tag, "lk_hit", {31'd0, lk_hit}, {31'd0, k >= 0});
    cmp(tag, "lk_paddr", lk_paddr, (k >= 0) ? model_pa(k, lva) : 32'd0);
    cmp(tag, "lk_l1_desc", lk_l1_desc, (k >= 0) ? m_l1[k] : 32'd0);
    cmp(tag, "lk_l2_desc", lk_l2_desc, (k >= 0) ? m_l2[k] : 32'd0);
    @(posedge clk);
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (fo) begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && ((fva & m_msk[i]) == m_adr[i])) m_v[i] = 0;
    end else if (fv) begin
      m_v[m_ptr] = 1; m_msk[m_ptr] = msk; m_adr[m_ptr] = va & msk;
      m_l1[m_ptr] = l1; m_l2[m_ptr] = l2; m_pg[m_ptr] = pg;
      m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] msk, logic [31:0] l1, logic [31:0] l2,
                      bit pg, logic [31:0] lva, string tag);
    step(0, 0, 0, 1, va, msk, l1, l2, pg, lva, tag);
  endtask

  task automatic idle(logic [31:0] lva, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, lva, tag);
  endtask

  function automatic logic [31:0] pick_mask(int s);
    case (s % 3)
      0: return 32'hFFF0_0000;
      1: return 32'hFFFF_0000;
      default: return 32'hFFFF_F000;
    endcase
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    #5;
    cmp("R1", "lk_hit at reset", {31'd0, lk_hit}, 32'd0);
    cmp("R1", "fill_ready at reset", {31'd0, fill_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle(32'h1234_5678, "R1");

    // R10 / R3 / R4: section mapping, visible right after its fill edge
    fill(32'h1234_5678, 32'hFFF0_0000, 32'hABC0_0C12, 32'h0, 0, 32'h123F_FFFF, "R10");
    idle(32'h123F_FFFF, "R10");
    idle(32'h1230_0004, "R3");
    // R3: small page, base from second-level descriptor
    fill(32'h4000_1234, 32'hFFFF_F000, 32'h1111_1111, 32'h7777_7ABC, 1, 32'h4000_1FFC, "R3");
    idle(32'h4000_1FFC, "R3");
    idle(32'h4000_2000, "R2");
    idle(32'h9900_0000, "R2");
    // R9: a page inside the section; the section (entry 0) wins
    fill(32'h1230_0000, 32'hFFFF_F000, 32'h2222_2222, 32'h3333_3000, 1, 32'h1230_0010, "R9");
    idle(32'h1230_0010, "R9");
    // R8: single flush removes both matching entries, keeps the other
    step(0, 1, 32'h1230_0010, 0, 0, 0, 0, 0, 0, 32'h1230_0010, "R8");
    idle(32'h1230_0010, "R8");
    idle(32'h4000_1008, "R8");
    // R6: a fill offered during a flush is not taken
    step(0, 1, 32'hEEEE_0000, 1, 32'h5000_0000, 32'hFFF0_0000, 32'h6000_0000, 0, 0,
         32'h5000_0000, "R6");
    idle(32'h5000_0000, "R6");
    // R7 precedence over flush_one
    step(1, 1, 32'h0, 0, 0, 0, 0, 0, 0, 32'h4000_1008, "R7");
    idle(32'h4000_1008, "R7");

    // R5: wrap; fill N+1 evicts the first
    for (int i = 0; i <= N; i++)
      fill({16'hC000 + 16'(i), 16'h0}, 32'hFFFF_0000, 32'h8000_0000 + (i << 16), 0, 0,
           32'hC000_0000, "R5");
    idle(32'hC000_0010, "R5");
    idle(32'hC001_0010, "R5");
    idle(32'hC040_0010, "R5");

    // R7: pointer reset seen through priority order
    for (int i = 0; i < N - 2; i++)
      fill({16'hD000 + 16'(i), 16'h0}, 32'hFFFF_0000, 32'h9000_0000, 0, 0, 32'h0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 32'hD000_0000, "R7");
    fill(32'h5550_0000, 32'hFFFF_F000, 32'h0, 32'h0ABC_D000, 1, 32'h5550_0004, "R7");
    fill(32'h5550_0000, 32'hFFF0_0000, 32'h0770_0000, 32'h0, 0, 32'h5550_0004, "R7");
    idle(32'h5550_0004, "R7");
    idle(32'h555F_0004, "R7");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [31:0] va, lva;
      op  = $urandom % 100;
      va  = {8'hA0 + 8'($urandom % 4), 24'($urandom)};
      lva = ($urandom % 10 < 7) ? {8'hA0 + 8'($urandom % 4), 24'($urandom)} : $urandom;
      if (op < 3)
        step(1, $urandom % 2, va, $urandom % 2, va, pick_mask($urandom), $urandom, $urandom,
             $urandom % 2, lva, "R7");
      else if (op < 12)
        step(0, 1, va, $urandom % 2, va, pick_mask($urandom), $urandom, $urandom,
             $urandom % 2, lva, "R8");
      else if (op < 60)
        fill(va, pick_mask($urandom), $urandom, $urandom, $urandom % 2, lva, "R5");
      else
        idle(lva, "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule